// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32768 Hz time base down to a programmable periodic tick. The time base reaches the block as a one-cycle enable strobe in the system clock domain. Each strobe advances a free-running phase counter. A 4-bit rate code selects a power-of-two period. A tick falls on every strobe that brings the phase counter to a whole multiple of that period, so ticks stay aligned to the 32 kHz count and do not depend on when the rate was programmed.

Two enables use the tick. With the interrupt enable set, a tick sets a periodic flag and a summary flag and drives the interrupt line. Flags and line stay set until the host acknowledges. With the pulse enable set, a tick drives a single-cycle pulse on the pulse output. The divider runs only when the rate code is nonzero and at least one enable is set. The phase counter keeps counting in every configuration.

Top module: `periodic_irq_divider`

## Requirements
- R1: After reset, irq_o, pf_o, irqf_o and sqw_o are low and the phase counter is zero.
- R2: With rate code 0, no tick occurs, whatever the enables are.
- R3: For rate codes 3 to 15, the period is 2^(code-1) strobes. Any run of N strobes, with N a multiple of the period, contains exactly N/period ticks.
- R4: Rate code 1 gives a period of 128 strobes and rate code 2 gives 256 strobes, the same as codes 8 and 9.
- R5: A tick occurs on a strobe exactly when the incremented phase count (modulo 2^CNT_W) has all of its low (period-1) bits at zero. Changing the rate code or the enables never resets the phase counter, and a change takes effect from the next strobe.
- R6: A tick with pie_en_i high sets pf_o and irqf_o and raises irq_o one cycle after the strobe. They stay high until acknowledged. A tick with pie_en_i low leaves them unchanged.
- R7: ack_i high for a cycle clears pf_o, irqf_o and irq_o on the next cycle. A tick in the same cycle as ack_i takes precedence, and the flags remain set.
- R8: A tick with sqw_en_i high drives sqw_o high for exactly one cycle, one cycle after the strobe. Otherwise sqw_o is low.
- R9: With both enables low, no tick occurs, but the phase counter still advances on every strobe.
- R10: In cycles without a strobe, no tick occurs and the phase counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick32k_i | input | 1 | One-cycle 32768 Hz enable strobe |
| rate_i | input | 4 | Rate code (0 = off) |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Pulse output enable |
| ack_i | input | 1 | Acknowledge, clears the flags |
| irq_o | output | 1 | Interrupt line |
| pf_o | output | 1 | Periodic flag |
| irqf_o | output | 1 | Summary interrupt flag |
| sqw_o | output | 1 | Single-cycle tick pulse |

## Verification
The bench builds the block with CNT_W = 14, the smallest width that holds the longest period of 16384 strobes. At this width the phase counter wraps after 16384 strobes. The longest-period windows therefore cross the wrap, which checks that ticks stay aligned through the rollover. Rate and enable changes happen mid-count without any reset, so the alignment after each change is also exercised against the reference model on every cycle.

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider #(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick32k_i,
  input  logic [3:0] rate_i,
  input  logic       pie_en_i,
  input  logic       sqw_en_i,
  input  logic       ack_i,
  output logic       irq_o,
  output logic       pf_o,
  output logic       irqf_o,
  output logic       sqw_o
);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_nx;
  logic [CNT_W-1:0] mask;
  logic [3:0]       eff_code;
  logic             run;
  logic             hit;
  logic             pf_q, irqf_q, sqw_q;

  assign eff_code = (rate_i == 4'd1 || rate_i == 4'd2) ? rate_i + 4'd7 : rate_i;
  assign mask     = (CNT_W'(1) << (eff_code - 4'd1)) - CNT_W'(1);
  assign run      = (rate_i != 4'd0) && (pie_en_i || sqw_en_i);
  assign phase_nx = phase_q + CNT_W'(1);
  assign hit      = tick32k_i && run && ((phase_nx & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pf_q    <= 1'b0;
      irqf_q  <= 1'b0;
      sqw_q   <= 1'b0;
    end else begin
      if (tick32k_i) phase_q <= phase_nx;
      if (hit && pie_en_i) begin
        pf_q   <= 1'b1;
        irqf_q <= 1'b1;
      end else if (ack_i) begin
        pf_q   <= 1'b0;
        irqf_q <= 1'b0;
      end
      sqw_q <= hit && sqw_en_i;
    end
  end

  assign pf_o   = pf_q;
  assign irqf_o = irqf_q;
  assign irq_o  = irqf_q;
  assign sqw_o  = sqw_q;

  AST_ZERO_RATE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == 4'd0) |=> !sqw_o); // R2
  AST_PF_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pf_o && !pie_en_i) |=> !pf_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_o && !ack_i) |=> pf_o); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick32k_i) |=> (!pf_o && !irq_o)); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_o |=> !sqw_o); // R8
  AST_NO_ENABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pie_en_i && !sqw_en_i) |=> (!sqw_o && $stable(pf_o) || !pf_o)); // R9
  AST_NO_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick32k_i && !pf_o) |=> (!sqw_o && !pf_o)); // R10

endmodule

// File: tb/sim_periodic_irq_divider.sv
module sim_periodic_irq_divider;
  localparam int CW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [3:0] rate = 4'd0;
  logic pie = 1'b0, sqe = 1'b0, ack = 1'b0;
  logic irq, pf, irqf, sqw;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  int  m_cnt = 0;
  bit  m_pf = 0, m_sqw = 0;

  always #10 clk = ~clk;

  periodic_irq_divider #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick32k_i(stb), .rate_i(rate),
    .pie_en_i(pie), .sqw_en_i(sqe), .ack_i(ack),
    .irq_o(irq), .pf_o(pf), .irqf_o(irqf), .sqw_o(sqw));

  function automatic int period_of(input int code);
    int e;
    e = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return 1 << (e - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pf = 0; m_sqw = 0;
    end else begin
      m_sqw = 0;
      if (ack) m_pf = 0;
      if (stb) begin
        m_cnt = (m_cnt + 1) % (1 << CW);
        if (rate != 0 && (pie || sqe) && (m_cnt % period_of(int'(rate))) == 0) begin
          if (pie) m_pf = 1;
          if (sqe) m_sqw = 1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {irq,pf,irqf,sqw} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) check(tag, {irq, pf, irqf, sqw}, {m_pf, m_pf, m_pf, m_sqw});
  end

  task automatic win(input int n, input int code, input bit p, input bit s,
                     input int ack_every, output int pulses);
    pulses = 0;
    rate = 4'(code); pie = p; sqe = s;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sqw) pulses++;
      stb = 1'b1;
      ack = (ack_every > 0) && (i % ack_every == 0);
    end
    @(negedge clk);
    if (sqw) pulses++;
    stb = 1'b0; ack = 1'b0;
  endtask

  task automatic cnt_check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: tick count actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    int np;
    fork
      begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        repeat (3) @(negedge clk);
        check("R1", {irq, pf, irqf, sqw}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {irq, pf, irqf, sqw}, 4'b0000);
        cmp_on = 1'b1;

        tag = "R2"; win(300, 0, 1, 1, 0, np); cnt_check("R2", np, 0);
        tag = "R9"; win(37, 3, 0, 0, 0, np);  cnt_check("R9", np, 0);
        tag = "R3"; win(64, 3, 0, 1, 0, np);  cnt_check("R3", np, 16);
        tag = "R3"; win(512, 6, 0, 1, 0, np); cnt_check("R3", np, 16);
        tag = "R4"; win(1024, 1, 0, 1, 0, np); cnt_check("R4", np, 8);
        tag = "R4"; win(1024, 2, 0, 1, 0, np); cnt_check("R4", np, 4);
        tag = "R6"; win(40, 4, 1, 0, 0, np);
        check("R6", {irq, pf, irqf, sqw}, 4'b1110);
        tag = "R7"; win(3, 4, 0, 0, 1, np);
        check("R7", {irq, pf, irqf, sqw}, 4'b0000);
        tag = "R7"; win(200, 3, 1, 1, 1, np);
        tag = "R10";
        rate = 4'd3; pie = 1'b1; sqe = 1'b1;
        repeat (50) @(negedge clk);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        repeat (20) @(negedge clk);
        check("R10", {irq, pf, irqf, sqw}, 4'b0000);
        tag = "R5";
        for (int k = 0; k < 20; k++) begin
          win(3 + k, 3 + (k % 5), k[0], 1, 4, np);
          repeat (k % 3) @(negedge clk);
        end
        tag = "R3"; win(32768, 15, 0, 1, 0, np); cnt_check("R3", np, 2);
        tag = "R5"; win(16384, 14, 1, 1, 7, np); cnt_check("R5", np, 2);
        cmp_on = 1'b0;
        @(negedge clk);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule